// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

This block is a byte-wide SPI port that works either as the bus master or as a slave, with the role set by a control input. It shares one 8-bit shift register between both directions. On every serial clock period it moves one bit out and takes one bit in, most significant bit first. The serial clock idles low. Outgoing data changes on the falling edge and incoming data is captured on the rising edge. As master, the block makes the serial clock by dividing the system clock. As slave, it passes the external clock, data and enable lines through two-flop synchronizers before it looks for edges.

Software selects synchronous operation, the role, and 3-wire or 4-wire operation. The block computes every pin's output enable from these settings and from the synchronized level of the shared enable line. In 4-wire operation, a master gives up the clock and data lines as soon as another device pulls that line low. If this happens during a frame, the frame is aborted and a sticky conflict flag is raised. A slave in 4-wire operation drives its return line and follows clock edges only while the enable line is low.

On the parallel side, a write strobe loads the outgoing byte and, as master, starts a frame. A one-cycle ready pulse marks each received byte.

Top module: `spi_dual_port`

## Requirements
- R1: After reset, busy, rx_ready and conflict are 0 and sck_out is 0.
- R2: With cfg_sync at 0, sck_oe, mosi_oe and miso_oe are all 0.
- R3: With cfg_sync and cfg_master at 1, sck_oe and mosi_oe are 1 when cfg_three_pin is 1 or the synchronized ste_in is 1, and 0 otherwise. miso_oe is 0. The ste_in level takes effect two clocks after it is applied.
- R4: With cfg_sync at 1 and cfg_master at 0, miso_oe is 1 when cfg_three_pin is 1 or the synchronized ste_in is 0. sck_oe and mosi_oe are 0.
- R5: A master frame sends the written byte MSB first on mosi_out and returns on rd_data the 8 bits read from miso_in. mosi_out changes only when sck_out falls, miso_in is captured when sck_out rises, and sck_out is 0 whenever no frame is in progress.
- R6: Each half period of the master sck_out lasts DIV system clocks, so busy stays high for 16*DIV clocks per frame.
- R7: rx_ready is high for exactly one clock at the end of each completed frame, and rd_data holds the received byte from that clock on.
- R8: A write strobe while busy is 1 is ignored. The frame in progress finishes with its original byte.
- R9: If a master frame is running and the master loses the right to drive (4-wire and ste_in low), the frame stops with no rx_ready, busy goes to 0, the pins are released, and conflict goes to 1. conflict stays 1 until conflict_clr is pulsed.
- R10: A 4-wire slave with ste_in high keeps miso_oe at 0, ignores sck_in edges, stays not busy and gives no rx_ready. With ste_in low it returns the loaded byte MSB first on miso_out and receives the mosi_in byte.
- R11: A 3-wire slave ignores ste_in. It drives miso_out and completes frames even with ste_in high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sync | input | 1 | Synchronous operation select |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_three_pin | input | 1 | 1 = 3-wire (enable ignored), 0 = 4-wire |
| wr_en | input | 1 | Write strobe: load transmit byte (starts a master frame) |
| wr_data | input | 8 | Transmit byte |
| rd_data | output | 8 | Last received byte |
| rx_ready | output | 1 | One-cycle pulse on frame completion |
| busy | output | 1 | Frame in progress |
| conflict | output | 1 | Sticky flag: master frame aborted by the enable line |
| conflict_clr | input | 1 | Clears conflict |
| ste_in | input | 1 | Shared enable line level |
| sck_in | input | 1 | Serial clock from the bus |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Output enable for the clock pin |
| mosi_in | input | 1 | Master-to-slave data from the bus |
| mosi_out | output | 1 | Master-to-slave data driven as master |
| mosi_oe | output | 1 | Output enable for the master data pin |
| miso_in | input | 1 | Slave-to-master data from the bus |
| miso_out | output | 1 | Slave-to-master data driven as slave |
| miso_oe | output | 1 | Output enable for the slave data pin |

## Verification
The assertions assume that the configuration inputs stay constant while a frame runs and that a slave's sck_in half periods are several system clocks longer than the synchronizer delay. The stimulus changes the mode only while busy is low. It drives slave edges with six-clock half periods and holds mosi_in steady across each whole bit. The master-side bus model changes miso_in only on falling edges of sck_out, which keeps the sampled value free of races. The enable line is toggled at arbitrary points, because the block resynchronizes it.

// File: rtl/spi_dp_pkg.sv
package spi_dp_pkg;
    localparam int DATA_W = 8;
    localparam int BIT_W  = $clog2(DATA_W + 1);

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic sck_oe;
        logic mosi_oe;
        logic miso_oe;
    } pin_ctl_t;
endpackage

// File: rtl/spi_dp_sync.sv
module spi_dp_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stg
        logic [W-1:0] r_q;
        logic [W-1:0] src;
        if (g == 0) begin : g_first
            assign src = d;
        end else begin : g_next
            assign src = g_stg[g-1].r_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= RST_VAL;
            else        r_q <= src;
        end
    end

    assign q = g_stg[STAGES-1].r_q;
endmodule

// File: rtl/spi_dp_dir.sv
module spi_dp_dir
    import spi_dp_pkg::*;
(
    input  logic     cfg_sync,
    input  logic     cfg_master,
    input  logic     cfg_three_pin,
    input  logic     ste_s,
    output pin_ctl_t ctl,
    output logic     drive_m,
    output logic     slv_sel
);
    always_comb begin
        drive_m     = cfg_sync & cfg_master & (cfg_three_pin | ste_s);
        slv_sel     = cfg_sync & ~cfg_master & (cfg_three_pin | ~ste_s);
        ctl.sck_oe  = drive_m;
        ctl.mosi_oe = drive_m;
        ctl.miso_oe = slv_sel;
    end
endmodule

// File: rtl/spi_dp_core.sv
module spi_dp_core
    import spi_dp_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_master,
    input  logic  drive_m,
    input  logic  slv_sel,
    input  logic  wr_en,
    input  word_t wr_data,
    input  logic  conflict_clr,
    input  logic  sck_s,
    input  logic  mosi_s,
    input  logic  miso_in,
    output logic  sck_out,
    output logic  mosi_out,
    output logic  miso_out,
    output logic  busy,
    output word_t rd_data,
    output logic  rx_ready,
    output logic  conflict
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0]    div;
        logic             sck;
        logic             sck_prev;
        logic [BIT_W-1:0] bits;
        word_t            sh;
        logic             rxb;
        logic             mbusy;
        word_t            rd;
        logic             rdy;
        logic             cfl;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     rise, fall;

    always_comb begin
        st_d          = st_q;
        st_d.rdy      = 1'b0;
        st_d.sck_prev = sck_s;
        rise          = sck_s & ~st_q.sck_prev;
        fall          = ~sck_s & st_q.sck_prev;
        if (conflict_clr) st_d.cfl = 1'b0;

        if (st_q.mbusy) begin
            if (!drive_m) begin
                st_d.mbusy = 1'b0;
                st_d.sck   = 1'b0;
                st_d.bits  = '0;
                st_d.div   = '0;
                st_d.cfl   = 1'b1;
            end else if (st_q.div == CW'(DIV - 1)) begin
                st_d.div = '0;
                if (!st_q.sck) begin
                    st_d.sck  = 1'b1;
                    st_d.rxb  = miso_in;
                    st_d.bits = st_q.bits + 1'b1;
                end else begin
                    st_d.sck = 1'b0;
                    st_d.sh  = {st_q.sh[DATA_W-2:0], st_q.rxb};
                    if (st_q.bits == BIT_W'(DATA_W)) begin
                        st_d.mbusy = 1'b0;
                        st_d.bits  = '0;
                        st_d.rd    = {st_q.sh[DATA_W-2:0], st_q.rxb};
                        st_d.rdy   = 1'b1;
                    end
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end else if (cfg_master) begin
            if (wr_en && drive_m) begin
                st_d.sh    = wr_data;
                st_d.mbusy = 1'b1;
                st_d.div   = '0;
                st_d.bits  = '0;
                st_d.sck   = 1'b0;
            end
        end else begin
            if (!slv_sel) begin
                st_d.bits = '0;
            end else if (rise) begin
                st_d.rxb  = mosi_s;
                st_d.bits = st_q.bits + 1'b1;
            end else if (fall && st_q.bits != '0) begin
                st_d.sh = {st_q.sh[DATA_W-2:0], st_q.rxb};
                if (st_q.bits == BIT_W'(DATA_W)) begin
                    st_d.bits = '0;
                    st_d.rd   = {st_q.sh[DATA_W-2:0], st_q.rxb};
                    st_d.rdy  = 1'b1;
                end
            end
            if (wr_en && st_q.bits == '0) st_d.sh = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck_out  = st_q.sck;
    assign mosi_out = st_q.sh[DATA_W-1];
    assign miso_out = st_q.sh[DATA_W-1];
    assign busy     = st_q.mbusy | (st_q.bits != '0);
    assign rd_data  = st_q.rd;
    assign rx_ready = st_q.rdy;
    assign conflict = st_q.cfl;

    a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rdy |=> !st_q.rdy);
    a_r7_ready_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rdy |-> $past(busy));
    a_r9_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfl && !conflict_clr) |=> st_q.cfl);
    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mbusy |-> !st_q.sck);
    a_r8_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mbusy && $past(st_q.mbusy) && !(st_q.sck == 1'b0 && $past(st_q.sck)))
        |-> $stable(st_q.sh));
endmodule

// File: rtl/spi_dual_port.sv
module spi_dual_port
    import spi_dp_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sync,
    input  logic              cfg_master,
    input  logic              cfg_three_pin,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              busy,
    output logic              conflict,
    input  logic              conflict_clr,
    input  logic              ste_in,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe
);
    logic [2:0] raw, synced;
    pin_ctl_t   ctl;
    logic       drive_m, slv_sel;

    assign raw = {ste_in, mosi_in, sck_in};

    spi_dp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (synced)
    );

    spi_dp_dir u_dir (
        .cfg_sync      (cfg_sync),
        .cfg_master    (cfg_master),
        .cfg_three_pin (cfg_three_pin),
        .ste_s         (synced[2]),
        .ctl           (ctl),
        .drive_m       (drive_m),
        .slv_sel       (slv_sel)
    );

    spi_dp_core #(.DIV(DIV)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_master   (cfg_master),
        .drive_m      (drive_m),
        .slv_sel      (slv_sel),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .conflict_clr (conflict_clr),
        .sck_s        (synced[0]),
        .mosi_s       (synced[1]),
        .miso_in      (miso_in),
        .sck_out      (sck_out),
        .mosi_out     (mosi_out),
        .miso_out     (miso_out),
        .busy         (busy),
        .rd_data      (rd_data),
        .rx_ready     (rx_ready),
        .conflict     (conflict)
    );

    assign sck_oe  = ctl.sck_oe;
    assign mosi_oe = ctl.mosi_oe;
    assign miso_oe = ctl.miso_oe;

    a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_oe && miso_oe));
    a_r9_release_on_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conflict) |-> !sck_oe && !busy);
endmodule

// File: tb/spi_dual_port_tb.sv
module spi_dual_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int H          = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sync = 1'b0, cfg_master = 1'b0, cfg_three_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rx_ready, busy, conflict;
    logic       conflict_clr = 1'b0;
    logic       ste_in = 1'b1, sck_in = 1'b0, mosi_in = 1'b0;
    logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
    logic       miso_in;

    logic [7:0] mdl = '0;
    logic [7:0] cap = '0;
    logic [7:0] exp_q[$];
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_dual_port #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_master(cfg_master),
        .cfg_three_pin(cfg_three_pin), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rx_ready(rx_ready), .busy(busy), .conflict(conflict),
        .conflict_clr(conflict_clr), .ste_in(ste_in), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .mosi_in(mosi_in), .mosi_out(mosi_out),
        .mosi_oe(mosi_oe), .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe)
    );

    // bus slave model for master-mode frames
    assign miso_in = mdl[7];
    always @(posedge sck_out) cap <= {cap[6:0], mosi_out};
    always @(negedge sck_out) mdl <= {mdl[6:0], 1'b0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected rx_ready", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R7 rd_data at ready", int'(rd_data), int'(e));
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_data = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic master_xfer(input logic [7:0] mo, input logic [7:0] mi,
                               input bit extra_wr, input string req);
        int cnt;
        mdl = mi;
        cap = '0;
        exp_q.push_back(mi);
        write_byte(mo);
        cnt = 1;
        while (busy) begin
            if (extra_wr && cnt == 20) begin
                wr_data = ~mo; wr_en = 1'b1;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        wr_en = 1'b0;
        check(cnt - 1 == 16*DIV, "R6 frame length", cnt - 1, 16*DIV);
        wait_clk(2);
        check(cap == mo, req, int'(cap), int'(mo));
        check(sck_out == 1'b0, "R5 sck idle low", int'(sck_out), 0);
    endtask

    task automatic slave_clock(input logic [7:0] mo);
        for (int i = 7; i >= 0; i--) begin
            mosi_in = mo[i];
            wait_clk(H);
            sck_in = 1'b1;
            wait_clk(H);
            cap = {cap[6:0], miso_out};
            sck_in = 1'b0;
            wait_clk(H);
        end
        wait_clk(6);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        check(!busy && !rx_ready && !conflict && !sck_out, "R1 reset state",
              {busy, rx_ready, conflict, sck_out}, 0);
        // R2 not synchronous
        check({sck_oe, mosi_oe, miso_oe} == 3'b000, "R2 oe off", {sck_oe, mosi_oe, miso_oe}, 0);

        // R3 master, 3-wire, ste low ignored
        cfg_sync = 1'b1; cfg_master = 1'b1; cfg_three_pin = 1'b1; ste_in = 1'b0;
        wait_clk(4);
        check({sck_oe, mosi_oe, miso_oe} == 3'b110, "R3 master 3-wire oe",
              {sck_oe, mosi_oe, miso_oe}, 3'b110);
        master_xfer(8'hA5, 8'h3C, 1'b0, "R5 mosi byte A5");
        master_xfer(8'h01, 8'h80, 1'b0, "R5 mosi byte 01");
        // R8 write while busy
        master_xfer(8'h6E, 8'hD2, 1'b1, "R8 original byte kept");

        // R3 master, 4-wire
        cfg_three_pin = 1'b0; ste_in = 1'b1;
        wait_clk(4);
        check({sck_oe, mosi_oe} == 2'b11, "R3 4-wire ste high drives", {sck_oe, mosi_oe}, 3);
        master_xfer(8'hC3, 8'h5A, 1'b0, "R5 4-wire mosi byte C3");
        ste_in = 1'b0;
        @(negedge clk);
        check(sck_oe == 1'b1, "R3 ste latency", int'(sck_oe), 1);
        wait_clk(3);
        check({sck_oe, mosi_oe, miso_oe} == 3'b000, "R3 4-wire ste low released",
              {sck_oe, mosi_oe, miso_oe}, 0);

        // R9 conflict
        ste_in = 1'b1; wait_clk(4);
        mdl = 8'hFF;
        write_byte(8'h99);
        wait_clk(20);
        check(busy == 1'b1, "R9 frame running", int'(busy), 1);
        ste_in = 1'b0;
        wait_clk(5);
        check(!busy && conflict && !sck_oe && !sck_out, "R9 abort",
              {busy, conflict, sck_oe, sck_out}, 4'b0100);
        ste_in = 1'b1;
        wait_clk(10);
        check(conflict == 1'b1, "R9 sticky", int'(conflict), 1);
        @(negedge clk); conflict_clr = 1'b1;
        @(negedge clk); conflict_clr = 1'b0;
        @(negedge clk);
        check(conflict == 1'b0, "R9 cleared", int'(conflict), 0);

        // R4 / R10 slave 4-wire
        cfg_master = 1'b0; ste_in = 1'b1;
        wait_clk(4);
        check({sck_oe, mosi_oe, miso_oe} == 3'b000, "R4 slave deselected oe",
              {sck_oe, mosi_oe, miso_oe}, 0);
        slave_clock(8'h77);
        check(busy == 1'b0, "R10 deselected edges ignored", int'(busy), 0);
        ste_in = 1'b0;
        wait_clk(4);
        check({sck_oe, mosi_oe, miso_oe} == 3'b001, "R4 slave selected oe",
              {sck_oe, mosi_oe, miso_oe}, 1);
        write_byte(8'h4B);
        cap = '0;
        exp_q.push_back(8'hE1);
        slave_clock(8'hE1);
        check(cap == 8'h4B, "R10 slave miso byte", int'(cap), 8'h4B);

        // R11 slave 3-wire, ste high ignored
        cfg_three_pin = 1'b1; ste_in = 1'b1;
        wait_clk(4);
        check(miso_oe == 1'b1, "R11 3-wire slave drives", int'(miso_oe), 1);
        write_byte(8'h2D);
        cap = '0;
        exp_q.push_back(8'h96);
        slave_clock(8'h96);
        check(cap == 8'h2D, "R11 slave miso byte", int'(cap), 8'h2D);

        // R2 again after leaving synchronous mode
        cfg_sync = 1'b0;
        wait_clk(2);
        check({sck_oe, mosi_oe, miso_oe} == 3'b000, "R2 oe off later",
              {sck_oe, mosi_oe, miso_oe}, 0);
        check(exp_q.size() == 0, "R7 all frames reported", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule